// File: doc/BRIEF.md
# Identification Page Write Controller

This block is the receiving end of a serial memory port that handles one command: writing bytes into a 128-byte identification page. While the select line is low, the host shifts in a command byte, two address bytes and a stream of data bytes. The data is loaded into a page buffer, and the write pointer wraps inside the page. When the select line is released, the block decides whether the command is valid and allowed. If it is, the block starts a timed write cycle, and at the end of that cycle the buffered bytes are copied into an internal byte array.

The serial lines are oversampled in the system clock domain through synchronizers. The protection state is supplied on pins: a block-protect pair and a page-lock flag. A single-cycle pulse, issued by whatever decodes the write-enable command, sets the write-enable latch. The write-enable latch and the write-in-progress flag are outputs. The array can be read combinationally through a read address port.

Top module: `idpage_wr_ctrl`

## Requirements
- R1: The serial input is sampled on rising serial-clock edges, most significant bit first. A high select line resets the bit and byte framing.
- R2: The first byte must equal 8'h82. With any other value the rest of that select period is ignored: the array and the write-enable latch are left unchanged.
- R3: The second and third bytes form a 16-bit address, high byte first. Bits 6:0 give the starting byte. Bits 15:11 and 9:7 have no effect. If bit 10 is 1, the command is rejected.
- R4: Each data byte is stored at the current pointer, and then only the 7-bit pointer is incremented. Byte 127 is followed by byte 0, and a later byte replaces an earlier byte at the same location.
- R5: A committed write changes only the locations that received a data byte. All other locations keep their contents.
- R6: A command is committed only if the select line rises after a whole number of data bytes, with at least one data byte. Otherwise it is discarded.
- R7: A command is rejected while the write-enable latch is 0.
- R8: A command is rejected while block-protect equals 2'b11. Other block-protect values do not block it.
- R9: A command is rejected while the page-lock input is 1.
- R10: A command is rejected if a write cycle is running at select fall or at select rise. The running cycle completes with its own data.
- R11: An accepted command raises write-in-progress for exactly WRITE_CYCLES clock cycles. The array takes the new bytes when that flag falls.
- R12: The write-enable latch is set by a wel_set pulse only when no write cycle is running. It clears when a write cycle ends and when a command that began with 8'h82 is rejected or discarded.
- R13: After reset, write-in-progress and the write-enable latch are 0 and every array byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| wel_set | input | 1 | One-cycle pulse that sets the write-enable latch |
| bp_in | input | 2 | Block-protect bits |
| lock_in | input | 1 | Identification page lock |
| wel_o | output | 1 | Write-enable latch |
| wip_o | output | 1 | Write cycle in progress |
| rd_addr | input | $clog2(PAGE_BYTES) | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |

## Verification
The assertions assume that the serial clock is slow compared with the system clock, with every half period lasting at least three system clocks. They also assume that the data line is stable across each rising serial-clock edge, that select never toggles within two clocks of itself, and that block-protect and lock are held steady for the whole frame. The stimulus meets these conditions by changing every input on a falling system-clock edge and holding each serial-clock half for four clocks. It lets the select line settle for several clocks around each frame and changes the protection inputs only between frames. The random frames vary length, start address, don't-care address bits, opcode, trailing partial bits and protection state, and directed frames cover wraparound, overwrite and the busy case.

// File: rtl/idw_pkg.sv
package idw_pkg;

    typedef enum logic [1:0] {
        PH_OPC  = 2'd0,
        PH_AHI  = 2'd1,
        PH_ALO  = 2'd2,
        PH_DATA = 2'd3
    } phase_e;

    localparam int BYTE_W   = 8;
    localparam int SEL_BIT  = 10;   // address bit that must be zero
    localparam logic [1:0] BP_ALL = 2'b11;

endpackage

// File: rtl/idw_sync.sv
module idw_sync #(
    parameter int               STAGES  = 2,
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);

    typedef logic [STAGES-1:0][WIDTH-1:0] chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = raw;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign synced = chain_q[STAGES-1];

endmodule

// File: rtl/idw_decode.sv
module idw_decode
    import idw_pkg::*;
#(
    parameter int          PAGE_BYTES = 128,
    parameter logic [7:0]  CMD_OPCODE = 8'h82
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             sck_s,
    input  logic                             cs_s,
    input  logic                             mosi_s,
    input  logic                             wel,
    input  logic                             wip,
    input  logic [1:0]                       bp,
    input  logic                             lock,
    output logic                             go,
    output logic                             rej,
    output logic [PAGE_BYTES-1:0]            vmask,
    output logic [PAGE_BYTES-1:0][BYTE_W-1:0] pbuf
);

    localparam int PTR_W = $clog2(PAGE_BYTES);

    typedef struct packed {
        logic                              sck_p;
        logic                              cs_p;
        logic [2:0]                        bits;
        logic [BYTE_W-1:0]                 shreg;
        phase_e                            phase;
        logic                              cmd_hit;
        logic                              taint;
        logic                              got_data;
        logic [BYTE_W-1:0]                 ahi;
        logic [PTR_W-1:0]                  ptr;
        logic [PAGE_BYTES-1:0]             vmask;
        logic [PAGE_BYTES-1:0][BYTE_W-1:0] pbuf;
        logic                              go;
        logic                              rej;
    } st_t;

    st_t d, q;

    logic              sck_rise;
    logic              cs_rise;
    logic              cs_fall;
    logic              busy;
    logic              aligned;
    logic              accept;
    logic [BYTE_W-1:0] nb;

    always_comb begin
        d        = q;
        d.go     = 1'b0;
        d.rej    = 1'b0;
        d.sck_p  = sck_s;
        d.cs_p   = cs_s;
        sck_rise = sck_s & ~q.sck_p;
        cs_rise  = cs_s & ~q.cs_p;
        cs_fall  = ~cs_s & q.cs_p;
        busy     = wip | q.go;
        aligned  = (q.bits == 3'd0) && q.got_data;
        accept   = aligned && wel && (bp != BP_ALL) && !lock && !busy
                   && !q.taint && !q.ahi[SEL_BIT-BYTE_W];
        nb       = {q.shreg[BYTE_W-2:0], mosi_s};

        // verdict at deselect, only for the page-write opcode
        if (cs_rise && q.cmd_hit) begin
            d.go  = accept;
            d.rej = !accept;
        end

        if (cs_s) begin
            d.bits     = 3'd0;
            d.phase    = PH_OPC;
            d.cmd_hit  = 1'b0;
            d.got_data = 1'b0;
            d.taint    = 1'b0;
        end else begin
            if (cs_fall) begin
                d.taint = busy;
                if (!busy) begin
                    d.vmask = '0;
                end
            end
            if (sck_rise) begin
                d.shreg = nb;
                d.bits  = q.bits + 3'd1;
                if (q.bits == 3'd7) begin
                    unique case (q.phase)
                        PH_OPC: begin
                            d.cmd_hit = (nb == CMD_OPCODE);
                            d.phase   = PH_AHI;
                        end
                        PH_AHI: begin
                            d.ahi   = nb;
                            d.phase = PH_ALO;
                        end
                        PH_ALO: begin
                            d.ptr   = nb[PTR_W-1:0];
                            d.phase = PH_DATA;
                        end
                        PH_DATA: begin
                            d.got_data = 1'b1;
                            if (q.cmd_hit && !q.taint) begin
                                d.pbuf[q.ptr]  = nb;
                                d.vmask[q.ptr] = 1'b1;
                                d.ptr          = q.ptr + PTR_W'(1);
                            end
                        end
                        default: d.phase = PH_OPC;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign go    = q.go;
    assign rej   = q.rej;
    assign vmask = q.vmask;
    assign pbuf  = q.pbuf;

endmodule

// File: rtl/idw_commit.sv
module idw_commit
    import idw_pkg::*;
#(
    parameter int PAGE_BYTES   = 128,
    parameter int WRITE_CYCLES = 1000
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              go,
    input  logic                              rej,
    input  logic                              wel_set,
    input  logic [PAGE_BYTES-1:0]             vmask,
    input  logic [PAGE_BYTES-1:0][BYTE_W-1:0] pbuf,
    input  logic [$clog2(PAGE_BYTES)-1:0]     rd_addr,
    output logic                              wip,
    output logic                              wel,
    output logic [BYTE_W-1:0]                 rd_data,
    output logic [PAGE_BYTES*BYTE_W-1:0]      mem_flat
);

    localparam int TW = $clog2(WRITE_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(WRITE_CYCLES - 1);

    typedef struct packed {
        logic                              wip;
        logic                              wel;
        logic [TW-1:0]                     timer;
        logic [PAGE_BYTES-1:0][BYTE_W-1:0] mem;
    } st_t;

    st_t d, q;

    always_comb begin
        d = q;
        if (q.wip) begin
            if (q.timer == LAST) begin
                d.wip = 1'b0;
                d.wel = 1'b0;
                for (int i = 0; i < PAGE_BYTES; i++) begin
                    if (vmask[i]) begin
                        d.mem[i] = pbuf[i];
                    end
                end
            end else begin
                d.timer = q.timer + TW'(1);
            end
        end else if (go) begin
            d.wip   = 1'b1;
            d.timer = '0;
        end
        if (wel_set && !q.wip) begin
            d.wel = 1'b1;
        end
        if (rej) begin
            d.wel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wip      = q.wip;
    assign wel      = q.wel;
    assign rd_data  = q.mem[rd_addr];
    assign mem_flat = q.mem;

endmodule

// File: rtl/idpage_wr_ctrl.sv
module idpage_wr_ctrl
    import idw_pkg::*;
#(
    parameter int         PAGE_BYTES   = 128,
    parameter int         WRITE_CYCLES = 1000,
    parameter logic [7:0] CMD_OPCODE   = 8'h82,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          spi_sck,
    input  logic                          spi_cs_n,
    input  logic                          spi_mosi,
    input  logic                          wel_set,
    input  logic [1:0]                    bp_in,
    input  logic                          lock_in,
    output logic                          wel_o,
    output logic                          wip_o,
    input  logic [$clog2(PAGE_BYTES)-1:0] rd_addr,
    output logic [7:0]                    rd_data
);

    logic [2:0]                        sync_w;
    logic                              go_w;
    logic                              rej_w;
    logic                              wip_w;
    logic                              wel_w;
    logic [PAGE_BYTES-1:0]             vmask_w;
    logic [PAGE_BYTES-1:0][BYTE_W-1:0] pbuf_w;
    logic [PAGE_BYTES*BYTE_W-1:0]      mem_w;

    idw_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (3),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({spi_sck, spi_cs_n, spi_mosi}),
        .synced(sync_w)
    );

    idw_decode #(
        .PAGE_BYTES(PAGE_BYTES),
        .CMD_OPCODE(CMD_OPCODE)
    ) u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .sck_s (sync_w[2]),
        .cs_s  (sync_w[1]),
        .mosi_s(sync_w[0]),
        .wel   (wel_w),
        .wip   (wip_w),
        .bp    (bp_in),
        .lock  (lock_in),
        .go    (go_w),
        .rej   (rej_w),
        .vmask (vmask_w),
        .pbuf  (pbuf_w)
    );

    idw_commit #(
        .PAGE_BYTES  (PAGE_BYTES),
        .WRITE_CYCLES(WRITE_CYCLES)
    ) u_commit (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go_w),
        .rej     (rej_w),
        .wel_set (wel_set),
        .vmask   (vmask_w),
        .pbuf    (pbuf_w),
        .rd_addr (rd_addr),
        .wip     (wip_w),
        .wel     (wel_w),
        .rd_data (rd_data),
        .mem_flat(mem_w)
    );

    assign wel_o = wel_w;
    assign wip_o = wip_w;

endmodule

// File: rtl/idw_checker.sv
module idw_checker #(
    parameter int PAGE_BYTES   = 128,
    parameter int WRITE_CYCLES = 1000
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    go,
    input logic                    rej,
    input logic                    wip,
    input logic                    wel,
    input logic [PAGE_BYTES*8-1:0] mem
);

    localparam int RW = $clog2(WRITE_CYCLES + 1) + 1;

    logic [RW-1:0] run_d, run_q;

    always_comb begin
        run_d = wip ? run_q + RW'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    // R11
    wip_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> (run_q < RW'(WRITE_CYCLES)));

    // R11
    go_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> wip);

    // R11
    wip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(go));

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(wip) |-> $stable(mem));

    // R7
    go_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> wel);

    // R10
    go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !wip);

    // R6
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(go && rej));

    // R12
    rej_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rej |=> !wel);

    // R12
    end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);

endmodule

bind idpage_wr_ctrl idw_checker #(
    .PAGE_BYTES  (PAGE_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (go_w),
    .rej  (rej_w),
    .wip  (wip_w),
    .wel  (wel_w),
    .mem  (mem_w)
);

// File: tb/idpage_wr_ctrl_tb.sv
module idpage_wr_ctrl_tb;

    localparam int CYC = 600;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       wel_set = 1'b0;
    logic [1:0] bp = 2'b00;
    logic       lock = 1'b0;
    logic       wel, wip;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;

    int errs = 0;
    int checks = 0;
    logic [7:0] exp_mem [128];
    logic [7:0] dbuf [256];
    logic       exp_wel = 1'b0;

    always #10 clk = ~clk;

    idpage_wr_ctrl #(.WRITE_CYCLES(CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .wel_set(wel_set), .bp_in(bp), .lock_in(lock),
        .wel_o(wel), .wip_o(wip), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) mosi = b;
        repeat (4) @(posedge clk);
        @(negedge clk) sck = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk) sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    // frame leaves select high and returns at once
    task automatic frame(input logic [7:0] opc, input logic [15:0] adr,
                         input int n, input int extra);
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(posedge clk);
        send_byte(opc);
        send_byte(adr[15:8]);
        send_byte(adr[7:0]);
        for (int i = 0; i < n; i++) send_byte(dbuf[i]);
        for (int i = 0; i < extra; i++) send_bit(1'($urandom));
        repeat (4) @(posedge clk);
        @(negedge clk) cs_n = 1'b1;
    endtask

    task automatic pulse_wel();
        @(negedge clk) wel_set = 1'b1;
        @(negedge clk) wel_set = 1'b0;
    endtask

    // model of the accept rule and the array update (R2..R10)
    function automatic bit predict(input logic [7:0] opc, input logic [15:0] adr,
                                   input int n, input int extra, input bit busy);
        bit ok;
        logic [6:0] p;
        if (opc != 8'h82) return 1'b0;
        ok = (n >= 1) && (extra == 0) && exp_wel && (bp != 2'b11) && !lock
             && !busy && !adr[10];
        if (ok) begin
            p = adr[6:0];
            for (int i = 0; i < n; i++) begin
                exp_mem[p] = dbuf[i];
                p = p + 7'd1;
            end
        end else begin
            exp_wel = 1'b0;
        end
        return ok;
    endfunction

    task automatic wip_len(output int n);
        n = 0;
        for (int g = 0; g < CYC + 300; g++) begin
            @(negedge clk);
            if (wip) n++;
            else if (n > 0) break;
            else if (g > 40) break;
        end
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        int first = -1;
        logic [7:0] got = 8'h00;
        for (int a = 0; a < 128; a++) begin
            @(negedge clk) rd_addr = 7'(a);
            #1;
            if (rd_data !== exp_mem[a]) begin
                bad++;
                if (first < 0) begin
                    first = a;
                    got = rd_data;
                end
            end
        end
        chk(bad == 0, req, int'(got), (first < 0) ? 0 : int'(exp_mem[first]));
    endtask

    // full transaction: frame, measure write cycle, compare array and latch
    task automatic run_frame(input logic [7:0] opc, input logic [15:0] adr,
                             input int n, input int extra, input string req);
        bit acc;
        int len;
        acc = predict(opc, adr, n, extra, 1'b0);
        frame(opc, adr, n, extra);
        wip_len(len);
        chk(len == (acc ? CYC : 0), {req, " R11 write cycle length"}, len, acc ? CYC : 0);
        if (acc) exp_wel = 1'b0;
        repeat (4) @(negedge clk);
        chk(wel == exp_wel, {req, " R12 latch"}, int'(wel), int'(exp_wel));
        cmp_mem(req);
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int len;
        void'($urandom(32'h1D5E_0821));
        for (int a = 0; a < 128; a++) exp_mem[a] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R13 reset state
        chk(wip == 1'b0, "R13 wip after reset", int'(wip), 0);
        chk(wel == 1'b0, "R13 wel after reset", int'(wel), 0);
        cmp_mem("R13 array after reset");

        // R12 latch set
        pulse_wel(); exp_wel = 1'b1;
        @(negedge clk);
        chk(wel == 1'b1, "R12 wel_set", int'(wel), 1);

        // R1 R4 R5 basic write of three bytes
        fill(3);
        run_frame(8'h82, 16'h0010, 3, 0, "R1 R5 basic");

        // R4 wrap at end of page
        pulse_wel(); exp_wel = 1'b1;
        fill(5);
        run_frame(8'h82, 16'h007E, 5, 0, "R4 wrap");

        // R3 R4 don't-care address bits and overwrite after full lap
        pulse_wel(); exp_wel = 1'b1;
        fill(130);
        run_frame(8'h82, 16'hFB85, 130, 0, "R3 R4 overwrite");

        // R3 bit 10 set rejects
        pulse_wel(); exp_wel = 1'b1;
        fill(4);
        run_frame(8'h82, 16'h0420, 4, 0, "R3 bit10 reject");

        // R6 partial byte and missing data byte
        pulse_wel(); exp_wel = 1'b1;
        fill(2);
        run_frame(8'h82, 16'h0030, 2, 3, "R6 partial byte");
        pulse_wel(); exp_wel = 1'b1;
        run_frame(8'h82, 16'h0030, 0, 0, "R6 no data");

        // R7 latch clear
        fill(2);
        run_frame(8'h82, 16'h0040, 2, 0, "R7 no latch");

        // R8 full protect rejects, partial protect allows
        pulse_wel(); exp_wel = 1'b1;
        bp = 2'b11; fill(2);
        run_frame(8'h82, 16'h0050, 2, 0, "R8 protect 11");
        pulse_wel(); exp_wel = 1'b1;
        bp = 2'b10; fill(2);
        run_frame(8'h82, 16'h0050, 2, 0, "R8 protect 10");
        bp = 2'b00;

        // R9 lock
        pulse_wel(); exp_wel = 1'b1;
        lock = 1'b1; fill(2);
        run_frame(8'h82, 16'h0060, 2, 0, "R9 locked");
        lock = 1'b0;

        // R2 foreign opcode leaves latch and array
        pulse_wel(); exp_wel = 1'b1;
        fill(3);
        run_frame(8'h03, 16'h0000, 3, 0, "R2 foreign opcode");

        // R10 command during a running cycle
        fill(2);
        void'(predict(8'h82, 16'h0070, 2, 0, 1'b0));
        frame(8'h82, 16'h0070, 2, 0);
        repeat (8) @(negedge clk);
        chk(wip == 1'b1 && wel == 1'b1, "R10 first cycle running", int'({wip, wel}), 3);
        fill(1);
        dbuf[0] = 8'hA5;
        void'(predict(8'h82, 16'h0071, 1, 0, 1'b1));
        frame(8'h82, 16'h0071, 1, 0);
        repeat (6) @(negedge clk);
        chk(wel == 1'b0, "R10 busy reject clears latch", int'(wel), 0);
        pulse_wel();
        @(negedge clk);
        chk(wel == 1'b0, "R12 wel_set ignored while busy", int'(wel), 0);
        wip_len(len);
        exp_wel = 1'b0;
        chk(wip == 1'b0, "R10 first cycle ends", int'(wip), 0);
        cmp_mem("R10 only first frame written");

        // random frames
        for (int k = 0; k < 20; k++) begin
            logic [7:0]  opc;
            logic [15:0] adr;
            int n, extra;
            opc = ($urandom % 8 == 0) ? 8'($urandom) : 8'h82;
            adr = 16'($urandom);
            if ($urandom % 8 != 0) adr[10] = 1'b0;
            n = ($urandom % 10 == 0) ? 100 + $urandom % 40 : 1 + $urandom % 16;
            if ($urandom % 16 == 0) n = 0;
            extra = ($urandom % 8 == 0) ? 1 + $urandom % 7 : 0;
            bp = ($urandom % 4 == 0) ? 2'b11 : 2'($urandom % 3);
            lock = ($urandom % 8 == 0);
            if ($urandom % 4 != 0) begin
                pulse_wel(); exp_wel = 1'b1;
            end
            fill(n);
            run_frame(opc, adr, n, extra, "R1 R4 R5 R6 random");
        end
        bp = 2'b00;
        lock = 1'b0;

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule